// File: doc/BRIEF.md
# Serial Host Port for Slice Data Readout

This block is the host-facing side of a data slicer. A host microcontroller drives four pins: an active-low chip enable, a shift clock, a data pin and a direction input. With the direction input low, the host shifts in a 16-bit line-select word, which chooses the video lines the slicer watches. With the direction input high, the host clocks out the captured slice data. That data is held in five 32-bit buffers, which the capture side fills through a simple load interface.

The data pin is open-drain. The block never drives it high. It only asserts a pull-low enable, and an external pull-up supplies the high level. The block brings all four host pins into the system clock domain through a synchroniser and detects their edges there. The host must therefore keep each clock phase several system clock periods long.

When a read starts, the block copies all five buffers into a single stream register. A capture that arrives while the read is under way therefore cannot mix old and new data in one readout.

Top module: `slice_host_port`

## Requirements
- R1: After reset, `line_sel` is 0 and `host_sdio_pull_low` is 0.
- R2: In write mode (direction low at the chip-enable falling edge), the data pin is sampled on each rising shift-clock edge. If exactly 16 rising edges occur before chip enable returns high, `line_sel` takes the shifted word. The first bit sent lands in bit 15 and the last in bit 0.
- R3: A transfer with any rising-edge count other than 16 leaves `line_sel` unchanged on chip-enable release. So does a transfer made in read mode.
- R4: While chip enable is high, the shift clock and data pin have no effect. `host_sdio_pull_low` stays 0 and `line_sel` is unchanged.
- R5: In read mode (direction high at the chip-enable falling edge), the pin presents the first bit of the stream without any clock edge. Each falling shift-clock edge advances one bit. The stream is 160 bits in this order: `cap_sel` 0 first, then 1 to 4, each word most significant bit first. A 0 bit asserts `host_sdio_pull_low`; a 1 bit releases it.
- R6: Once all 160 bits have been shifted out, further falling edges leave the pin released.
- R7: The stream is a snapshot taken at the chip-enable falling edge. A load made during a read does not change the bits being streamed, and it appears in the next read.
- R8: A load accepted in the same clock cycle in which the chip-enable falling edge is acted on is included in that read's snapshot. A load one cycle later is not included.
- R9: `host_sdio_pull_low` is never asserted during a write-mode transfer.
- R10: A load with `cap_sel` of 5 or more changes no buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip enable from host, active low |
| host_sclk | input | 1 | Shift clock from host |
| host_sdio_in | input | 1 | Sensed level of the open-drain data pin |
| host_dir | input | 1 | 1 = read (block drives), 0 = write (host drives) |
| host_sdio_pull_low | output | 1 | Pull-low enable for the data pin |
| cap_valid | input | 1 | Load strobe from the capture side |
| cap_sel | input | 3 | Buffer index 0..4 for the load |
| cap_word | input | 32 | Word to store |
| line_sel | output | 16 | Committed line-select word |

## Verification
Two events can fall in the same clock cycle: a load from the capture side and the snapshot taken when a read begins. The bench times the load strobe against the synchronised chip-enable edge. It places the strobe one cycle before the edge is acted on, in the same cycle, and one cycle after. In each case it predicts which buffer value the read must return. It then reads again to confirm that the late load was stored all the same. Loads in the middle of a stream test the same isolation across a longer window.

// File: rtl/slice_port_pkg.sv
`timescale 1ns/1ps
package slice_port_pkg;
  localparam int unsigned DEF_NUM_BUF = 5;
  localparam int unsigned DEF_BUF_W   = 32;
  localparam int unsigned DEF_MASK_W  = 16;
  localparam int unsigned DEF_SYNC    = 2;
  localparam logic DIR_READ  = 1'b1;
  localparam logic DIR_WRITE = 1'b0;
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
module sp_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sp_capture_bank.sv
`timescale 1ns/1ps
module sp_capture_bank #(
  parameter int unsigned NUM_BUF = 5,
  parameter int unsigned BUF_W   = 32,
  parameter int unsigned IDX_W   = 3,
  localparam int unsigned TOTAL  = NUM_BUF * BUF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_valid,
  input  logic [IDX_W-1:0] cap_sel,
  input  logic [BUF_W-1:0] cap_word,
  output logic [TOTAL-1:0] snap_flat
);
  // Slot 0 occupies the top of the flat vector so it streams first.
  for (genvar g = 0; g < int'(NUM_BUF); g++) begin : g_slot
    logic [BUF_W-1:0] slot_q;
    logic             hit;

    assign hit = cap_valid && (cap_sel == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)      slot_q <= '0;
      else if (hit) slot_q <= cap_word;
    end

    // Write-through so a load coinciding with the snapshot is captured.
    assign snap_flat[(NUM_BUF-g)*BUF_W-1 -: BUF_W] = hit ? cap_word : slot_q;
  end
endmodule

// File: rtl/sp_shift_engine.sv
`timescale 1ns/1ps
module sp_shift_engine
  import slice_port_pkg::*;
#(
  parameter int unsigned NUM_BUF = 5,
  parameter int unsigned BUF_W   = 32,
  parameter int unsigned MASK_W  = 16,
  localparam int unsigned TOTAL  = NUM_BUF * BUF_W,
  localparam int unsigned CNT_W  = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              dir_s,
  input  logic [TOTAL-1:0]  snap_flat,
  output logic [MASK_W-1:0] line_mask,
  output logic              pull_low,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic              sck_fall,
  output logic              xfer_on,
  output logic              rd_mode,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic [MASK_W-1:0] wr_word,
  output logic              rd_head
);
  logic              cs_prev, sclk_prev, sck_rise;
  logic [TOTAL-1:0]  rsh_q, rsh_n;
  logic [MASK_W-1:0] wsh_n, mask_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              xfer_n, rd_n, pull_n;

  assign cs_fall  = cs_prev && !cs_n_s;
  assign cs_rise  = !cs_prev && cs_n_s;
  assign sck_rise = !sclk_prev && sclk_s;
  assign sck_fall = sclk_prev && !sclk_s;
  assign rd_head  = rsh_q[TOTAL-1];

  always_comb begin
    xfer_n = xfer_on;
    rd_n   = rd_mode;
    cnt_n  = edge_cnt;
    rsh_n  = rsh_q;
    wsh_n  = wr_word;
    mask_n = line_mask;
    if (cs_fall) begin
      xfer_n = 1'b1;
      rd_n   = (dir_s == DIR_READ);
      cnt_n  = '0;
      rsh_n  = snap_flat;
    end else if (cs_rise) begin
      xfer_n = 1'b0;
      if (xfer_on && !rd_mode && edge_cnt == CNT_W'(MASK_W)) mask_n = wr_word;
    end else if (xfer_on) begin
      if (rd_mode && sck_fall) begin
        rsh_n = {rsh_q[TOTAL-2:0], 1'b1};
        if (edge_cnt < CNT_W'(TOTAL)) cnt_n = edge_cnt + 1'b1;
      end
      if (!rd_mode && sck_rise) begin
        wsh_n = {wr_word[MASK_W-2:0], din_s};
        if (edge_cnt <= CNT_W'(MASK_W)) cnt_n = edge_cnt + 1'b1;
      end
    end
    pull_n = xfer_n && rd_n && !rsh_n[TOTAL-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      xfer_on   <= 1'b0;
      rd_mode   <= 1'b0;
      edge_cnt  <= '0;
      rsh_q     <= '1;
      wr_word   <= '0;
      line_mask <= '0;
      pull_low  <= 1'b0;
    end else begin
      cs_prev   <= cs_n_s;
      sclk_prev <= sclk_s;
      xfer_on   <= xfer_n;
      rd_mode   <= rd_n;
      edge_cnt  <= cnt_n;
      rsh_q     <= rsh_n;
      wr_word   <= wsh_n;
      line_mask <= mask_n;
      pull_low  <= pull_n;
    end
  end
endmodule

// File: rtl/slice_host_port.sv
`timescale 1ns/1ps
module slice_host_port
  import slice_port_pkg::*;
#(
  parameter int unsigned NUM_BUF     = DEF_NUM_BUF,
  parameter int unsigned BUF_W       = DEF_BUF_W,
  parameter int unsigned MASK_W      = DEF_MASK_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned IDX_W      = $clog2(NUM_BUF),
  localparam int unsigned TOTAL_BITS = NUM_BUF * BUF_W,
  localparam int unsigned CNT_W      = $clog2(TOTAL_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_sclk,
  input  logic              host_sdio_in,
  input  logic              host_dir,
  output logic              host_sdio_pull_low,
  input  logic              cap_valid,
  input  logic [IDX_W-1:0]  cap_sel,
  input  logic [BUF_W-1:0]  cap_word,
  output logic [MASK_W-1:0] line_sel
);
  logic [3:0]            pins_s;
  logic [TOTAL_BITS-1:0] snap_flat;
  logic                  cs_fall, cs_rise, sck_fall, xfer_on, rd_mode, rd_head;
  logic [CNT_W-1:0]      edge_cnt;
  logic [MASK_W-1:0]     wr_word;

  // Pin order {dir, data, clock, enable}; idle levels 0,1,0,1.
  sp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_dir, host_sdio_in, host_sclk, host_cs_n}),
    .q   (pins_s)
  );

  sp_capture_bank #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cap_valid (cap_valid),
    .cap_sel   (cap_sel),
    .cap_word  (cap_word),
    .snap_flat (snap_flat)
  );

  sp_shift_engine #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W), .MASK_W(MASK_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (pins_s[0]),
    .sclk_s    (pins_s[1]),
    .din_s     (pins_s[2]),
    .dir_s     (pins_s[3]),
    .snap_flat (snap_flat),
    .line_mask (line_sel),
    .pull_low  (host_sdio_pull_low),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sck_fall  (sck_fall),
    .xfer_on   (xfer_on),
    .rd_mode   (rd_mode),
    .edge_cnt  (edge_cnt),
    .wr_word   (wr_word),
    .rd_head   (rd_head)
  );
endmodule

// File: rtl/slice_host_port_chk.sv
`timescale 1ns/1ps
module slice_host_port_chk #(
  parameter int unsigned MASK_W = 16,
  parameter int unsigned TOTAL  = 160,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              pull_low,
  input logic [MASK_W-1:0] line_mask,
  input logic              cs_rise,
  input logic              cs_fall,
  input logic              sck_fall,
  input logic              xfer_on,
  input logic              rd_mode,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic [MASK_W-1:0] wr_word,
  input logic              rd_head
);
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !pull_low);

  // R2
  mask_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && xfer_on && !rd_mode && edge_cnt == CNT_W'(MASK_W))
      |=> (line_mask == $past(wr_word)));

  // R3
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_rise || rd_mode || edge_cnt != CNT_W'(MASK_W)) |=> $stable(line_mask));

  // R6
  drained_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && edge_cnt == CNT_W'(TOTAL)) |-> !pull_low);

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_on && rd_mode && !sck_fall && !cs_fall) |=> $stable(rd_head));

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_on && rd_mode && sck_fall && !cs_rise && edge_cnt < CNT_W'(TOTAL))
      |=> (edge_cnt == $past(edge_cnt) + 1'b1));
endmodule

bind slice_host_port slice_host_port_chk #(
  .MASK_W (MASK_W),
  .TOTAL  (TOTAL_BITS),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (host_cs_n),
  .pull_low  (host_sdio_pull_low),
  .line_mask (line_sel),
  .cs_rise   (cs_rise),
  .cs_fall   (cs_fall),
  .sck_fall  (sck_fall),
  .xfer_on   (xfer_on),
  .rd_mode   (rd_mode),
  .edge_cnt  (edge_cnt),
  .wr_word   (wr_word),
  .rd_head   (rd_head)
);

// File: tb/slice_host_port_tb.sv
`timescale 1ns/1ps
module slice_host_port_tb;
  localparam int NB = 5;
  localparam int BW = 32;
  localparam int MW = 16;
  localparam int TOT = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, sclk = 1'b0, host_bit = 1'b1, dir = 1'b0;
  logic          cap_valid = 1'b0;
  logic [2:0]    cap_sel = '0;
  logic [31:0]   cap_word = '0;
  logic          pull_low;
  logic [MW-1:0] line_sel;
  wire           sdio = host_bit & ~pull_low;

  int checks = 0, errors = 0, wr_pull_seen = 0;
  logic [31:0]   model [NB];
  logic [31:0]   got   [NB];
  logic [MW-1:0] mask_model = '0;

  always #5 clk = ~clk;

  slice_host_port u_dut (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_sclk(sclk),
    .host_sdio_in(sdio), .host_dir(dir), .host_sdio_pull_low(pull_low),
    .cap_valid(cap_valid), .cap_sel(cap_sel), .cap_word(cap_word),
    .line_sel(line_sel)
  );

  // R9: watch the pin during write mode
  always @(negedge clk) if (!rst && !dir && pull_low) wr_pull_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load(input int idx, input logic [31:0] data);
    cap_valid = 1'b1; cap_sel = 3'(idx); cap_word = data;
    @(negedge clk);
    cap_valid = 1'b0;
    if (idx < NB) model[idx] = data;
  endtask

  task automatic do_write(input logic [31:0] bits, input int n, input logic rdm);
    dir = rdm; wait_n(4);
    cs_n = 1'b0; wait_n(8);
    for (int i = n - 1; i >= 0; i--) begin
      host_bit = bits[i]; wait_n(4);
      sclk = 1'b1; wait_n(8);
      sclk = 1'b0; wait_n(4);
    end
    host_bit = 1'b1;
    cs_n = 1'b1; wait_n(8);
    dir = 1'b0; wait_n(2);
    if (n == MW && !rdm) mask_model = bits[MW-1:0];
  endtask

  // lk: negedges after cs low at which to load (0 = none); mk: bit index for mid-read load (-1 none)
  task automatic do_read(input int lk, input int lidx, input logic [31:0] ldata,
                         input int mk, input int midx, input logic [31:0] mdata,
                         input string tag);
    logic [31:0] exp_w [NB];
    int drained_bad;
    for (int w = 0; w < NB; w++) exp_w[w] = model[w];
    if (lk > 0 && lk <= 2 && lidx < NB) exp_w[lidx] = ldata;
    dir = 1'b1; wait_n(4);
    cs_n = 1'b0;
    @(negedge clk);
    if (lk > 0) begin
      wait_n(lk - 1);
      pulse_load(lidx, ldata);
      wait_n(8 - lk);
    end else wait_n(8);
    for (int b = 0; b < TOT; b++) begin
      got[b / BW][BW - 1 - (b % BW)] = ~pull_low;
      if (b == mk) pulse_load(midx, mdata);
      sclk = 1'b1; wait_n(8);
      sclk = 1'b0; wait_n(8);
    end
    drained_bad = 0;
    for (int e = 0; e < 6; e++) begin
      if (pull_low) drained_bad++;
      sclk = 1'b1; wait_n(8);
      sclk = 1'b0; wait_n(8);
    end
    chk({tag, " R6 drained pulls"}, 32'(drained_bad), 32'd0);
    cs_n = 1'b1; wait_n(8);
    dir = 1'b0; wait_n(2);
    for (int w = 0; w < NB; w++)
      chk($sformatf("%s R5 word%0d", tag, w), got[w], exp_w[w]);
  endtask

  initial begin
    for (int w = 0; w < NB; w++) model[w] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_n(2);
    chk("R1 line_sel", 32'(line_sel), 32'd0);
    chk("R1 pull_low", 32'(pull_low), 32'd0);

    // R4: clocks and data with enable high
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        host_bit = i[0]; sclk = 1'b1; wait_n(6);
        if (pull_low) seen++;
        sclk = 1'b0; wait_n(6);
      end
      host_bit = 1'b1;
      chk("R4 pull while idle", 32'(seen), 32'd0);
      chk("R4 line_sel idle", 32'(line_sel), 32'd0);
    end

    // R2: exact 16-bit writes
    do_write(32'h0000_A5C3, 16, 1'b0); chk("R2 A5C3", 32'(line_sel), 32'(mask_model));
    do_write(32'h0000_8000, 16, 1'b0); chk("R2 msb", 32'(line_sel), 32'(mask_model));
    do_write(32'h0000_0001, 16, 1'b0); chk("R2 lsb", 32'(line_sel), 32'(mask_model));
    do_write(32'h0000_FFFF, 16, 1'b0); chk("R2 ones", 32'(line_sel), 32'h0000_FFFF);

    // R3 / R2: sweep of clock counts 0..20
    for (int n = 0; n <= 20; n++) begin
      logic [31:0] pat;
      pat = 32'h1357_9BDF ^ (32'(n) * 32'h0000_9E37);
      do_write(pat, n, 1'b0);
      chk($sformatf("R3 count %0d", n), 32'(line_sel), 32'(mask_model));
    end
    // R3: 16 clocks in read mode leave line_sel alone
    do_write(32'h0000_0F0F, 16, 1'b1);
    chk("R3 read-mode write", 32'(line_sel), 32'(mask_model));

    // R5: fill buffers and read
    for (int w = 0; w < NB; w++) pulse_load(w, 32'hC0DE_0000 + 32'(w) * 32'h0101_1111);
    do_read(0, 0, '0, -1, 0, '0, "base");
    for (int w = 0; w < NB; w++) pulse_load(w, w[0] ? 32'hAAAA_AAAA : 32'h5555_0000);
    do_read(0, 0, '0, -1, 0, '0, "alt");

    // R10: out-of-range index
    pulse_load(5, 32'hDEAD_BEEF);
    pulse_load(7, 32'h0BAD_F00D);
    do_read(0, 0, '0, -1, 0, '0, "R10 range");

    // R7: loads during the stream
    do_read(0, 0, '0, 10, 3, 32'h1111_2222, "R7 mid a");
    do_read(0, 0, '0, 100, 0, 32'h3333_4444, "R7 next");
    chk("R7 load visible", got[3], 32'h1111_2222);

    // R8: load against snapshot edge
    do_read(1, 2, 32'h0246_8ACE, -1, 0, '0, "R8 early");
    do_read(2, 4, 32'h1357_0000, -1, 0, '0, "R8 same");
    do_read(3, 1, 32'hFEED_0001, -1, 0, '0, "R8 late");
    do_read(0, 0, '0, -1, 0, '0, "R8 after late");

    chk("R9 pull in write mode", 32'(wr_pull_seen), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-reqs act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule